// File: doc/BRIEF.md
# Temperature Conversion Sequencer

This block decides when a temperature conversion runs and owns the 12-bit result register that software later reads. It has two operating regimes chosen by a shutdown configuration bit. With shutdown clear, conversions run back to back without a gap. With shutdown set, the sequencer lets the conversion in flight finish and then goes quiet. From that quiet state a single conversion can be requested by a configuration write that carries the one-shot bit.

A 2-bit resolution code sets two things for each conversion: its length, which doubles with every step of the code, and how many low result bits are forced to zero. The analog converter is not part of the block. A stub drives a raw 12-bit sample that is captured at the end of each conversion. Durations are counted in clock ticks from a base parameter, so a simulation stays short.

Top module: `tsense_conv_seq`

## Requirements
- R1: A conversion started with resolution code c (0 to 3) lasts BASE_TICKS * 2^c clock cycles, counted from the edge that starts it to the edge that ends it.
- R2: A conversion finished with code c stores the raw sample with its lowest 3 - c bits forced to zero; code 0 keeps 9 bits and code 3 keeps all 12 bits.
- R3: `conv_done_o` is high for exactly one cycle per completed conversion, in the same cycle that `temp_o` takes its new value; `temp_o` changes in no other cycle.
- R4: While reset is held, `temp_o` is 0 and `conv_done_o` and `active_o` are low. With all configuration inputs at zero, the first clock edge after reset release starts a conversion at code 0, so the first result appears BASE_TICKS + 1 edges after release.
- R5: With `shutdown_i` low, a new conversion starts on the same edge that the previous one ends, and `active_o` stays high between them.
- R6: When `shutdown_i` is set during a conversion, that conversion completes and stores its result. `active_o` then falls on that same edge, and no further results appear.
- R7: A configuration write (`cfg_wr_i` high) with `oneshot_i` high while idle in shutdown starts exactly one conversion on the next edge. The block returns to idle when that conversion ends.
- R8: A one-shot write while a conversion is running has no effect: the running conversion ends at its original time and the next one follows at the normal interval.
- R9: A change of `res_sel_i` during a conversion changes neither that conversion's length nor its masking. It applies from the next conversion start.
- R10: A configuration write with `oneshot_i` low while idle in shutdown starts nothing and leaves `temp_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| shutdown_i | input | 1 | Configuration bit: 1 requests shutdown after the current conversion |
| res_sel_i | input | 2 | Resolution code: 0 = 9 bits, 1 = 10, 2 = 11, 3 = 12 |
| cfg_wr_i | input | 1 | One-cycle strobe marking a configuration write |
| oneshot_i | input | 1 | One-shot bit carried by the configuration write |
| sample_i | input | 12 | Raw sample from the converter model |
| temp_o | output | 12 | Temperature result register |
| conv_done_o | output | 1 | One-cycle pulse when a result is stored |
| active_o | output | 1 | 1 while converting, 0 while idle in shutdown |

## Verification
The hardest situations to reach from the ports are those where a configuration input changes partway through a conversion. Examples are shutdown arriving after a conversion has started, a resolution change that must wait for the next start, and a one-shot write that lands on a running conversion. The stimulus first waits for a done pulse, which fixes where the next conversion starts. It then counts a known number of cycles before changing the input, so the remaining time to the next result can be computed exactly. Every resolution code is combined with a set of samples that have different low-bit patterns, and each captured value is checked against an arithmetic shift-and-mask.

// File: rtl/tsense_pkg.sv
package tsense_pkg;
  localparam int TEMP_W   = 12;
  localparam int RES_W    = 2;
  localparam int MIN_BITS = 9;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } seq_state_e;

  // Keeps the top (MIN_BITS + code) bits of a result and clears the rest.
  function automatic logic [TEMP_W-1:0] keep_mask(input logic [RES_W-1:0] code);
    logic [TEMP_W-1:0] m;
    m = '1;
    m = m << ((TEMP_W - MIN_BITS) - int'(code));
    return m;
  endfunction
endpackage

// File: rtl/tsense_conv_timer.sv
module tsense_conv_timer #(
  parameter int BASE_TICKS = 8,
  parameter int RES_W      = 2,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [RES_W-1:0] res_i,
  output logic             expire_o
);
  localparam int MAX_SPAN = BASE_TICKS << ((1 << RES_W) - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, span;
  logic             cnt_en;

  always_comb begin
    span   = CNT_W'(BASE_TICKS) << res_i;
    cnt_en = load_i | run_i;
    cnt_d  = cnt_q;
    if (load_i)
      cnt_d = span - CNT_W'(1);
    else if (run_i && (cnt_q != '0))
      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign expire_o = run_i && (cnt_q == '0);

  // R1: the countdown never exceeds the longest conversion
  assert_count_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < MAX_SPAN);

  // R1: a running count that has not expired moves down by one
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/tsense_result_reg.sv
module tsense_result_reg
  import tsense_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [RES_W-1:0]  res_i,
  input  logic [TEMP_W-1:0] sample_i,
  output logic [TEMP_W-1:0] temp_o,
  output logic              done_o
);
  logic [TEMP_W-1:0] temp_q, temp_d;
  logic              done_q;

  always_comb begin
    temp_d = sample_i & keep_mask(res_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      temp_q <= '0;
    else if (capture_i)
      temp_q <= temp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      done_q <= 1'b0;
    else
      done_q <= capture_i;
  end

  assign temp_o = temp_q;
  assign done_o = done_q;

  // R3: the result only moves together with the done pulse
  assert_temp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(temp_q));
endmodule

// File: rtl/tsense_conv_seq.sv
module tsense_conv_seq
  import tsense_pkg::*;
#(
  parameter int BASE_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shutdown_i,
  input  logic [1:0]        res_sel_i,
  input  logic              cfg_wr_i,
  input  logic              oneshot_i,
  input  logic [TEMP_W-1:0] sample_i,
  output logic [TEMP_W-1:0] temp_o,
  output logic              conv_done_o,
  output logic              active_o
);
  localparam int MAX_SPAN = BASE_TICKS << ((1 << RES_W) - 1);
  localparam int CNT_W    = $clog2(MAX_SPAN) + 1;

  seq_state_e       state_q, state_d;
  logic [RES_W-1:0] res_q;
  logic             start, expire, running, single_req;

  assign running    = (state_q == ST_CONV);
  assign single_req = cfg_wr_i && oneshot_i;

  always_comb begin
    start   = 1'b0;
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (!shutdown_i || single_req) begin
          start   = 1'b1;
          state_d = ST_CONV;
        end
      end
      ST_CONV: begin
        if (expire) begin
          if (shutdown_i)
            state_d = ST_IDLE;
          else
            start = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= ST_IDLE;
    else
      state_q <= state_d;
  end

  // Resolution is sampled once per conversion, at its start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      res_q <= '0;
    else if (start)
      res_q <= res_sel_i;
  end

  tsense_conv_timer #(
    .BASE_TICKS (BASE_TICKS),
    .RES_W      (RES_W),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (start),
    .run_i    (running),
    .res_i    (res_sel_i),
    .expire_o (expire)
  );

  tsense_result_reg u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (expire),
    .res_i     (res_q),
    .sample_i  (sample_i),
    .temp_o    (temp_o),
    .done_o    (conv_done_o)
  );

  assign active_o = running;

  // R3: a result only follows a cycle spent converting
  assert_done_after_conv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done_o |-> $past(active_o));

  // R6: the sequencer goes idle only on a completed conversion
  assert_stop_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_o) |-> conv_done_o);

  // R2: low bits below the conversion's precision are zero
  assert_low_bits_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done_o |-> ((temp_o & ~keep_mask($past(res_q))) == '0));

  // R5: with shutdown clear the block never stays idle
  assert_continuous_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && !shutdown_i) |=> active_o);

  // R7: a one-shot write from idle starts a conversion
  assert_oneshot_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && cfg_wr_i && oneshot_i) |=> active_o);
endmodule

// File: tb/tsense_conv_seq_tb.sv
`timescale 1ns/1ps
module tsense_conv_seq_tb;
  localparam int BASE = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        shutdown_i, cfg_wr_i, oneshot_i;
  logic [1:0]  res_sel_i;
  logic [11:0] sample_i;
  logic [11:0] temp_o;
  logic        conv_done_o, active_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tsense_conv_seq #(.BASE_TICKS(BASE)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .shutdown_i  (shutdown_i),
    .res_sel_i   (res_sel_i),
    .cfg_wr_i    (cfg_wr_i),
    .oneshot_i   (oneshot_i),
    .sample_i    (sample_i),
    .temp_o      (temp_o),
    .conv_done_o (conv_done_o),
    .active_o    (active_o)
  );

  function automatic int span(input int c);
    return BASE << c;
  endfunction

  function automatic int msk(input int s, input int c);
    return ((s >> (3 - c)) << (3 - c)) & 12'hFFF;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic to_done(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!conv_done_o && cyc < 2000);
  endtask

  task automatic count_idle(input int n, output int dones);
    dones = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (conv_done_o) dones++;
    end
  endtask

  initial begin
    int cy, dn, prev, hold;
    int samples [6];
    samples = '{12'hFFF, 12'hA5C, 12'h7FF, 12'h801, 12'h193, 12'hFFD};
    rst_n = 1'b0; shutdown_i = 1'b0; res_sel_i = 2'd0;
    cfg_wr_i = 1'b0; oneshot_i = 1'b0; sample_i = 12'h7FF;
    repeat (3) @(negedge clk);
    check(temp_o == 12'h000, "R4 reset temp", temp_o, 0);
    check(conv_done_o == 1'b0, "R4 reset done", conv_done_o, 0);
    check(active_o == 1'b0, "R4 reset active", active_o, 0);

    rst_n = 1'b1;
    to_done(cy);
    check(cy == span(0) + 1, "R4 first result time", cy, span(0) + 1);
    check(int'(temp_o) == msk(12'h7FF, 0), "R2 first mask", temp_o, msk(12'h7FF, 0));
    @(negedge clk);
    check(conv_done_o == 1'b0, "R3 done width", conv_done_o, 0);
    to_done(cy);
    check(cy == span(0) - 1, "R5 back to back", cy, span(0) - 1);

    // Sweep every resolution code over several samples.
    prev = 0;
    for (int c = 0; c < 4; c++) begin
      res_sel_i = 2'(c);
      sample_i  = 12'(samples[0]);
      to_done(cy);
      check(cy == span(prev), "R9 old length kept", cy, span(prev));
      check(int'(temp_o) == msk(samples[0], prev), "R9 old mask kept", temp_o, msk(samples[0], prev));
      for (int k = 1; k < 6; k++) begin
        sample_i = 12'(samples[k]);
        to_done(cy);
        check(cy == span(c), "R1 length", cy, span(c));
        check(int'(temp_o) == msk(samples[k], c), "R2 mask", temp_o, msk(samples[k], c));
        check(active_o == 1'b1, "R5 stays active", active_o, 1);
      end
      prev = c;
    end

    res_sel_i = 2'd0;
    to_done(cy);
    check(cy == span(3), "R9 code 3 conversion", cy, span(3));

    // Shutdown requested partway through a code-0 conversion.
    repeat (2) @(negedge clk);
    shutdown_i = 1'b1;
    sample_i   = 12'h4B7;
    to_done(cy);
    check(cy == span(0) - 2, "R6 in-flight completes", cy, span(0) - 2);
    check(int'(temp_o) == msk(12'h4B7, 0), "R6 result stored", temp_o, msk(12'h4B7, 0));
    check(active_o == 1'b0, "R6 idle after", active_o, 0);
    hold = temp_o;
    count_idle(40, dn);
    check(dn == 0, "R6 no more results", dn, 0);
    check(int'(temp_o) == hold, "R6 result held", temp_o, hold);

    // Write without the one-shot bit.
    cfg_wr_i = 1'b1; oneshot_i = 1'b0;
    @(negedge clk);
    cfg_wr_i = 1'b0;
    check(active_o == 1'b0, "R10 no start", active_o, 0);
    count_idle(10, dn);
    check(dn == 0 && int'(temp_o) == hold, "R10 temp unchanged", temp_o, hold);

    // One-shot from shutdown at code 1.
    sample_i = 12'h321; res_sel_i = 2'd1;
    cfg_wr_i = 1'b1; oneshot_i = 1'b1;
    @(negedge clk);
    cfg_wr_i = 1'b0; oneshot_i = 1'b0;
    check(active_o == 1'b1, "R7 started", active_o, 1);
    to_done(cy);
    check(cy == span(1), "R7 single length", cy, span(1));
    check(int'(temp_o) == msk(12'h321, 1), "R7 single result", temp_o, msk(12'h321, 1));
    check(active_o == 1'b0, "R7 back to idle", active_o, 0);
    count_idle(50, dn);
    check(dn == 0, "R7 exactly one", dn, 0);

    // One-shot during continuous running is ignored.
    shutdown_i = 1'b0; res_sel_i = 2'd0;
    to_done(cy);
    check(cy == span(0) + 1, "R5 restart from idle", cy, span(0) + 1);
    repeat (2) @(negedge clk);
    cfg_wr_i = 1'b1; oneshot_i = 1'b1;
    @(negedge clk);
    cfg_wr_i = 1'b0; oneshot_i = 1'b0;
    to_done(cy);
    check(cy == span(0) - 3, "R8 end time unchanged", cy, span(0) - 3);
    to_done(cy);
    check(cy == span(0), "R8 next interval", cy, span(0));

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule